// File: doc/BRIEF.md
# Phase-Accumulator Frequency Divider

This block divides a clock by a programmable ratio. On every rising edge it adds a latched 16-bit tuning word, plus a one-bit carry, to a 16-bit registered accumulator. The accumulator's top bit is a square wave whose frequency is the clock frequency times the tuning word over 65536. At a 40 MHz clock this reaches at most 20 MHz, when the tuning word is 0x8000. The fifteen lower accumulator bits come out as a phase value, which can address an external waveform table.

New tuning words pass through a latch that is opened by an active-low load strobe. Switch inputs that bounce therefore never reach the accumulator between loads. Holding the strobe low makes the latch follow the input on every cycle.

A latched word of zero would leave the output stopped, so it selects bypass instead: the clock output then follows the input clock. An on-chip 16-bit Galois LFSR can supply the carry, which adds deliberate jitter to the output. When its enable is low, the LFSR holds its state and the carry is 0.

Top module: `nco_divider`

## Requirements
- R1: On each rising edge with reset low, the accumulator becomes (accumulator + latched tuning word + carry) modulo 65536.
- R2: `div_out` is bit 15 of the registered accumulator and `phase` is its bits 14:0. Both change only at rising edges.
- R3: The tuning word is captured at a rising edge where `load_n` is low and is held while `load_n` is high. The accumulator uses a captured word from the following edge onward.
- R4: With latched word 0x8000 and the carry at 0, `div_out` inverts on every cycle, giving half the clock frequency.
- R5: While the latched word is zero, `clk_out` equals `clk` in both clock phases. The accumulator keeps stepping by the carry.
- R6: While the latched word is nonzero, `clk_out` equals `div_out`.
- R7: With `dither_en` low, the carry is 0 and the LFSR state is held.
- R8: With `dither_en` high, the carry is LFSR bit 0, and at each edge the LFSR shifts right by one. When the bit shifted out is 1, the result is XORed with 0xB400. Reset loads the seed 0xACE1.
- R9: A synchronous reset clears the accumulator and the latched word, which enters bypass, and reseeds the LFSR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low strobe that captures the tuning word |
| tune_word | input | 16 | Tuning word, zero selects bypass |
| dither_en | input | 1 | Enables the LFSR as the carry source |
| div_out | output | 1 | Registered accumulator MSB |
| clk_out | output | 1 | Divided clock, or `clk` in bypass |
| phase | output | 15 | Registered accumulator bits 14:0 |

## Verification
A strobe seen at an edge changes the latched word at that edge. The accumulator, and so `div_out` and `phase`, first shows the effect one edge later, and the bench model reproduces both register stages. The model advances its latched word, LFSR and accumulator at each rising edge from the values held just before it. The registered outputs are compared 1 ns after each falling edge. `clk_out` is also compared 1 ns after each rising edge, so bypass is checked while the clock is high and while it is low.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned ACC_W      = 16;
  localparam int unsigned LFSR_W     = 16;
  localparam logic [15:0] LFSR_POLY  = 16'hB400;
  localparam logic [15:0] LFSR_SEED  = 16'hACE1;

  typedef enum logic [0:0] {
    MODE_DIVIDE = 1'b0,
    MODE_BYPASS = 1'b1
  } out_mode_e;
endpackage

// File: rtl/nco_tune_latch.sv
module nco_tune_latch #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_n,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] word_q,
  output logic         is_zero
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      is_zero <= 1'b1;
    end else if (!load_n) begin
      word_q  <= word_in;
      is_zero <= (word_in == '0);
    end
  end

  AST_TW_HOLD: assert property (@(posedge clk) disable iff (rst)
    load_n |=> $stable(word_q)) else $error("tuning word moved without strobe"); // R3

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!load_n && word_in == '0) |=> is_zero) else $error("zero word not flagged"); // R5
endmodule

// File: rtl/nco_dither_lfsr.sv
module nco_dither_lfsr #(
  parameter int unsigned   W    = 16,
  parameter logic [W-1:0]  POLY = 16'hB400,
  parameter logic [W-1:0]  SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  output logic carry
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_nx;
  logic         out_bit;

  assign out_bit = state_q[0];

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_tap
      if (gi == W - 1) begin : g_top
        assign state_nx[gi] = out_bit & POLY[gi];
      end else begin : g_mid
        assign state_nx[gi] = state_q[gi+1] ^ (out_bit & POLY[gi]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         state_q <= SEED;
    else if (enable) state_q <= state_nx;
  end

  assign carry = enable & out_bit;

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
    state_q != '0) else $error("LFSR locked at zero"); // R8

  AST_LFSR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(state_q)) else $error("LFSR moved while disabled"); // R7
endmodule

// File: rtl/nco_phase_accum.sv
module nco_phase_accum #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] step,
  input  logic         carry_in,
  output logic [W-1:0] acc_q
);
  logic [W-1:0] sum;

  always_comb begin
    sum = acc_q + step + {{(W-1){1'b0}}, carry_in};
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= sum;
  end

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> acc_q == '0) else $error("accumulator not cleared"); // R9

  AST_HALF_RATE: assert property (@(posedge clk) disable iff (rst)
    (step == {1'b1, {(W-1){1'b0}}} && !carry_in) |=> acc_q[W-1] != $past(acc_q[W-1]))
    else $error("MSB failed to invert at half rate"); // R4
endmodule

// File: rtl/nco_divider.sv
module nco_divider
  import nco_pkg::*;
#(
  parameter int unsigned   WORD_W = ACC_W,
  parameter logic [15:0]   POLY   = LFSR_POLY,
  parameter logic [15:0]   SEED   = LFSR_SEED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_n,
  input  logic [WORD_W-1:0] tune_word,
  input  logic              dither_en,
  output logic              div_out,
  output logic              clk_out,
  output logic [WORD_W-2:0] phase
);
  localparam int unsigned MSB = WORD_W - 1;

  logic [WORD_W-1:0] word_q;
  logic              word_zero;
  logic              carry;
  logic [WORD_W-1:0] acc_q;
  out_mode_e         mode;

  nco_tune_latch #(.W(WORD_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .load_n  (load_n),
    .word_in (tune_word),
    .word_q  (word_q),
    .is_zero (word_zero)
  );

  nco_dither_lfsr #(.W(16), .POLY(POLY), .SEED(SEED)) u_lfsr (
    .clk    (clk),
    .rst    (rst),
    .enable (dither_en),
    .carry  (carry)
  );

  nco_phase_accum #(.W(WORD_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .step     (word_q),
    .carry_in (carry),
    .acc_q    (acc_q)
  );

  assign mode    = word_zero ? MODE_BYPASS : MODE_DIVIDE;
  assign div_out = acc_q[MSB];
  assign phase   = acc_q[MSB-1:0];
  assign clk_out = (mode == MODE_BYPASS) ? clk : acc_q[MSB];

  AST_RST_BYPASS: assert property (@(posedge clk)
    rst |=> (mode == MODE_BYPASS)) else $error("reset did not select bypass"); // R9

  AST_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (!dither_en && word_q == '0) |=> $stable(acc_q)) else $error("acc moved with no step"); // R7
endmodule

// File: tb/nco_divider_tb.sv
module nco_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_n = 1'b1;
  logic [15:0] tune_word = 16'h0;
  logic        dither_en = 1'b0;
  logic        div_out, clk_out;
  logic [14:0] phase;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // behavioural model state
  int m_acc = 0;
  int m_tw = 0;
  int m_lfsr = 'hACE1;
  int prev_msb = 0;

  always #2 clk = ~clk;

  nco_divider dut_i (
    .clk(clk), .rst(rst), .load_n(load_n), .tune_word(tune_word),
    .dither_en(dither_en), .div_out(div_out), .clk_out(clk_out), .phase(phase)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // model: R1, R3, R7, R8, R9
  always @(posedge clk) begin
    int cin;
    cycles++;
    prev_msb = (m_acc >> 15) & 1;
    if (rst) begin
      m_acc = 0; m_tw = 0; m_lfsr = 'hACE1;
    end else begin
      cin = dither_en ? (m_lfsr & 1) : 0;
      m_acc = (m_acc + m_tw + cin) & 'hFFFF;
      if (!load_n) m_tw = tune_word;
      if (dither_en) begin
        if (m_lfsr & 1) m_lfsr = (m_lfsr >> 1) ^ 'hB400;
        else            m_lfsr = m_lfsr >> 1;
      end
    end
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cycles);
      finish_run();
    end
  end

  // clock-high check of clk_out: R5, R6
  always @(posedge clk) begin
    #1;
    if (m_tw == 0) check("R5 clk_out high", clk_out, 1);
    else           check("R6 clk_out", clk_out, (m_acc >> 15) & 1);
  end

  // clock-low check of registered outputs: R1, R2, R5, R6
  always @(negedge clk) begin
    #1;
    check("R1/R2 div_out", div_out, (m_acc >> 15) & 1);
    check("R1/R2 phase", phase, m_acc & 'h7FFF);
    if (m_tw == 0) check("R5 clk_out low", clk_out, 0);
    else           check("R6 clk_out", clk_out, (m_acc >> 15) & 1);
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] w);
    @(negedge clk); tune_word = w; load_n = 1'b0;
    @(negedge clk); load_n = 1'b1;
  endtask

  initial begin
    idle(3);
    // R9 reset state
    check("R9 reset div_out", div_out, 0);
    check("R9 reset phase", phase, 0);
    rst = 1'b0;
    idle(5);   // bypass after reset, R5

    // R4 half-rate output
    load(16'h8000);
    idle(2);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      check("R4 toggle", div_out, prev_msb ^ 1);
    end

    // R3 bouncing inputs ignored while strobe high
    load(16'h1234);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); tune_word = 16'h1111 * (i % 15);
    end
    idle(500);

    // R8 dither on with nonzero word
    dither_en = 1'b1;
    load(16'h0101);
    idle(600);

    // R5 bypass with dither: accumulator keeps stepping by carry
    load(16'h0000);
    idle(300);
    dither_en = 1'b0;   // R7 frozen accumulator in bypass
    idle(50);

    // R3 strobe held low: word follows every cycle
    @(negedge clk); load_n = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); tune_word = 16'(i * 16'h0123 + 7);
    end
    load_n = 1'b1;
    dither_en = 1'b1;
    idle(200);

    // R9 mid-run reset
    @(negedge clk); rst = 1'b1;
    idle(2);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R9 reset clears acc", phase, 0);
    idle(20);
    load(16'hFFFF);
    idle(100);
    finish_run();
  end
endmodule